// File: doc/BRIEF.md
# ATM Cell Receive Bus Port (PHY Side)

This block sits on the physical-layer side of a cell-level receive bus and hands complete 53-octet ATM cells to the ATM layer. Octets arrive one per cycle from an internal producer and are collected in a small buffer of whole-cell slots. The ATM layer pulls cells out over a data bus that is either 8 or 16 bits wide. Each transfer carries an odd parity bit and a start-of-cell marker.

The ATM layer paces the transfer with an active-low read enable. The port answers in the cycle after it samples that enable low. Instead of tri-state pins, the block has a separate output-enable for each group of bus signals: low data byte, high data byte, start-of-cell and parity. An outside pad ring or mux uses these enables to share the bus.

A strap input sets the bus width while reset is held. The configuration register keeps that width bit, and a register write can change it later. A new width is applied only between cells, so a cell is never split across two widths. A cell-available flag tells the ATM layer when a whole cell is waiting.

Top module: `atm_rx_cell_port`

## Requirements
- R1: Every enabled transfer carries odd parity over the active width: bits [7:0] in 8-bit mode and bits [15:0] in 16-bit mode. Data bits together with the parity bit hold an odd number of ones.
- R2: `rx_soc` is high exactly on the enabled transfer that carries the first octet, or first octet pair, of a cell. It is low on every other transfer.
- R3: The output-enables go high only in a cycle that follows a cycle in which `rd_en_n` was sampled low. In such a cycle they are high whenever a complete cell is still pending after the previous cycle's transfer.
- R4: The start-of-cell and parity enables always equal the low-byte data enable. The high-byte enable equals the low-byte enable in 16-bit mode and is low in 8-bit mode.
- R5: While reset is held, `width_strap` is copied into bit 3 of the configuration register (`cfg_q[3]`). A 0 selects 16-bit mode and a 1 selects 8-bit mode.
- R6: In 16-bit mode a cell takes 27 transfers. Octet 2k goes on bits [15:8] and octet 2k+1 goes on bits [7:0]. The low byte of the 27th word is zero.
- R7: In 8-bit mode a cell takes 53 transfers with octet k on bits [7:0] of transfer k. Bits [15:8] are zero.
- R8: While the read enable pauses a cell, the data bus keeps showing the next untransferred word. The transfer resumes with that same word, with no word skipped or repeated.
- R9: `cell_avail` is high exactly when the buffer holds at least one complete cell. It falls in the cycle after the last word of the final queued cell is transferred.
- R10: A write to `cfg_q[3]` changes the bus width only at a cell boundary. A cell in progress finishes in the width it started with.
- R11: `cell_in_ready` is low while every cell slot holds a complete cell. Octets offered at that time are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| width_strap | input | 1 | Width strap sampled during reset (1 = 8-bit, 0 = 16-bit) |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | CFG_W | Configuration register write data |
| cfg_q | output | CFG_W | Configuration register contents |
| cell_in_valid | input | 1 | Octet offered by the internal producer |
| cell_in_byte | input | 8 | Offered octet |
| cell_in_ready | output | 1 | Buffer can accept an octet |
| rd_en_n | input | 1 | Read enable from the ATM layer, active low |
| cell_avail | output | 1 | At least one complete cell buffered |
| rx_data | output | 16 | Receive data bus |
| rx_soc | output | 1 | Start-of-cell marker |
| rx_par | output | 1 | Odd parity over the active width |
| rx_data_lo_oe | output | 1 | Output-enable for rx_data[7:0] |
| rx_data_hi_oe | output | 1 | Output-enable for rx_data[15:8] |
| rx_soc_oe | output | 1 | Output-enable for rx_soc |
| rx_par_oe | output | 1 | Output-enable for rx_par |

## Verification
Cells are filled with random octets, all-ones octets and an incrementing count. The all-ones cells show whether parity is formed over the active width alone, and the counting cells show any swapped or shifted octets. The read enable is driven at several random duty cycles, from always-on down to sparse. The sparse patterns show whether a paused word is held or skipped, and the always-on runs show whether back-to-back cells keep their start marker and cell-available timing. Width writes land in the middle of a cell and between cells under both strap settings. This shows whether the width changes only at a cell boundary.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

   typedef enum logic {
      BUS_W16 = 1'b0,
      BUS_W8  = 1'b1
   } bus_mode_e;

   function automatic logic odd_parity16(input logic [15:0] d);
      return ~(^d);
   endfunction

endpackage

// File: rtl/cell_store.sv
module cell_store #(
   parameter int OCTETS = 53,
   parameter int SLOTS  = 2,
   localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int OFW   = $clog2(OCTETS + 1),
   localparam int CW    = $clog2(SLOTS + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_valid,
   input  logic [7:0]     wr_byte,
   output logic           wr_ready,
   input  logic           rd_release,
   input  logic [OFW-1:0] rd_off_a,
   input  logic [OFW-1:0] rd_off_b,
   output logic [7:0]     rd_byte_a,
   output logic [7:0]     rd_byte_b,
   output logic [CW-1:0]  cell_cnt
);

   localparam int DEPTH = SLOTS * OCTETS;
   localparam int AW    = $clog2(DEPTH);

   logic [7:0]     mem [DEPTH];
   logic [SW-1:0]  wr_slot, rd_slot;
   logic [OFW-1:0] wr_off;
   logic           wr_fire, wr_done;
   logic [OFW-1:0] off_b_safe;

   function automatic logic [AW-1:0] lin(input logic [SW-1:0] s, input logic [OFW-1:0] o);
      return AW'(s) * AW'(OCTETS) + AW'(o);
   endfunction

   function automatic logic [SW-1:0] next_slot(input logic [SW-1:0] s);
      return (s == SW'(SLOTS - 1)) ? '0 : s + SW'(1);
   endfunction

   assign wr_ready = (cell_cnt < CW'(SLOTS));
   assign wr_fire  = wr_valid && wr_ready;
   assign wr_done  = wr_fire && (wr_off == OFW'(OCTETS - 1));

   always_ff @(posedge clk) begin
      if (wr_fire) mem[lin(wr_slot, wr_off)] <= wr_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_slot  <= '0;
         rd_slot  <= '0;
         wr_off   <= '0;
         cell_cnt <= '0;
      end else begin
         if (wr_fire) wr_off <= wr_done ? '0 : wr_off + OFW'(1);
         if (wr_done) wr_slot <= next_slot(wr_slot);
         if (rd_release) rd_slot <= next_slot(rd_slot);
         cell_cnt <= cell_cnt + CW'(wr_done) - CW'(rd_release);
      end
   end

   assign off_b_safe = (rd_off_b < OFW'(OCTETS)) ? rd_off_b : '0;
   assign rd_byte_a  = mem[lin(rd_slot, rd_off_a)];
   assign rd_byte_b  = mem[lin(rd_slot, off_b_safe)];

endmodule

// File: rtl/rx_bus_ctrl.sv
module rx_bus_ctrl #(
   parameter int OCTETS = 53,
   parameter int CW     = 2,
   localparam int XW    = $clog2(OCTETS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strap_mode8,
   input  logic          cfg_mode8,
   input  logic          rd_en_n,
   input  logic [CW-1:0] cell_cnt,
   output logic          oe_q,
   output logic          mode8_q,
   output logic [XW-1:0] word_idx,
   output logic          rd_release
);

   localparam int LAST8  = OCTETS - 1;
   localparam int LAST16 = (OCTETS + 1) / 2 - 1;

   logic          last_word;
   logic [CW-1:0] cnt_after;
   logic          oe_d;
   logic          at_boundary;

   assign last_word   = mode8_q ? (word_idx == XW'(LAST8)) : (word_idx == XW'(LAST16));
   assign rd_release  = oe_q && last_word;
   assign cnt_after   = cell_cnt - CW'(rd_release);
   assign oe_d        = !rd_en_n && (cnt_after != '0);
   assign at_boundary = rd_release || ((word_idx == '0) && !oe_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_q     <= 1'b0;
         mode8_q  <= strap_mode8;
         word_idx <= '0;
      end else begin
         oe_q <= oe_d;
         if (oe_q) word_idx <= last_word ? '0 : word_idx + XW'(1);
         if (at_boundary) mode8_q <= cfg_mode8;
      end
   end

endmodule

// File: rtl/word_pack.sv
module word_pack #(
   parameter int OCTETS = 53,
   localparam int XW    = $clog2(OCTETS),
   localparam int OFW   = $clog2(OCTETS + 1)
) (
   input  logic           mode8,
   input  logic [XW-1:0]  word_idx,
   output logic [OFW-1:0] off_a,
   output logic [OFW-1:0] off_b,
   input  logic [7:0]     byte_a,
   input  logic [7:0]     byte_b,
   output logic [15:0]    data16,
   output logic           par
);

   logic [7:0] lo16;

   assign off_a  = mode8 ? OFW'(word_idx) : OFW'({word_idx, 1'b0});
   assign off_b  = off_a + OFW'(1);
   assign lo16   = (off_b < OFW'(OCTETS)) ? byte_b : 8'h00;
   assign data16 = mode8 ? {8'h00, byte_a} : {byte_a, lo16};
   assign par    = cellrx_pkg::odd_parity16(data16);

endmodule

// File: rtl/atm_rx_cell_port.sv
module atm_rx_cell_port #(
   parameter int OCTETS    = 53,
   parameter int SLOTS     = 2,
   parameter int CFG_W     = 8,
   parameter int WIDTH_BIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             width_strap,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_q,
   input  logic             cell_in_valid,
   input  logic [7:0]       cell_in_byte,
   output logic             cell_in_ready,
   input  logic             rd_en_n,
   output logic             cell_avail,
   output logic [15:0]      rx_data,
   output logic             rx_soc,
   output logic             rx_par,
   output logic             rx_data_lo_oe,
   output logic             rx_data_hi_oe,
   output logic             rx_soc_oe,
   output logic             rx_par_oe
);

   localparam int XW  = $clog2(OCTETS);
   localparam int OFW = $clog2(OCTETS + 1);
   localparam int CW  = $clog2(SLOTS + 1);

   generate
      if (OCTETS < 2) begin : g_bad_octets
         $error("OCTETS must be at least 2");
      end
      if (SLOTS < 1) begin : g_bad_slots
         $error("SLOTS must be at least 1");
      end
      if (WIDTH_BIT >= CFG_W) begin : g_bad_cfg
         $error("WIDTH_BIT must lie inside the configuration register");
      end
   endgenerate

   logic           oe_q, mode8_q, rd_release;
   logic [XW-1:0]  word_idx;
   logic [CW-1:0]  cell_cnt;
   logic [OFW-1:0] off_a, off_b;
   logic [7:0]     byte_a, byte_b;
   logic [15:0]    data16;
   logic           par;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q            <= '0;
         cfg_q[WIDTH_BIT] <= width_strap;
      end else if (cfg_we) begin
         cfg_q <= cfg_wdata;
      end
   end

   cell_store #(.OCTETS(OCTETS), .SLOTS(SLOTS)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (cell_in_valid),
      .wr_byte    (cell_in_byte),
      .wr_ready   (cell_in_ready),
      .rd_release (rd_release),
      .rd_off_a   (off_a),
      .rd_off_b   (off_b),
      .rd_byte_a  (byte_a),
      .rd_byte_b  (byte_b),
      .cell_cnt   (cell_cnt)
   );

   rx_bus_ctrl #(.OCTETS(OCTETS), .CW(CW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .strap_mode8 (width_strap),
      .cfg_mode8   (cfg_q[WIDTH_BIT]),
      .rd_en_n     (rd_en_n),
      .cell_cnt    (cell_cnt),
      .oe_q        (oe_q),
      .mode8_q     (mode8_q),
      .word_idx    (word_idx),
      .rd_release  (rd_release)
   );

   word_pack #(.OCTETS(OCTETS)) u_pack (
      .mode8    (mode8_q),
      .word_idx (word_idx),
      .off_a    (off_a),
      .off_b    (off_b),
      .byte_a   (byte_a),
      .byte_b   (byte_b),
      .data16   (data16),
      .par      (par)
   );

   assign cell_avail    = (cell_cnt != '0);
   assign rx_data       = data16;
   assign rx_par        = par;
   assign rx_soc        = oe_q && (word_idx == '0);
   assign rx_data_lo_oe = oe_q;
   assign rx_soc_oe     = oe_q;
   assign rx_par_oe     = oe_q;
   assign rx_data_hi_oe = oe_q && (mode8_q == cellrx_pkg::BUS_W16);

endmodule

// File: rtl/atm_rx_cell_port_chk.sv
module atm_rx_cell_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rd_en_n,
   input logic        cell_in_ready,
   input logic        cell_avail,
   input logic [15:0] rx_data,
   input logic        rx_soc,
   input logic        rx_par,
   input logic        rx_data_lo_oe,
   input logic        rx_data_hi_oe,
   input logic        rx_soc_oe,
   input logic        rx_par_oe
);

   AST_PAR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_data_lo_oe |-> (^{rx_data, rx_par}) == 1'b1); // R1

   AST_SOC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_soc |-> rx_soc_oe); // R2

   AST_OE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rx_data_lo_oe |-> $past(!rd_en_n)); // R3

   AST_GROUPS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_soc_oe == rx_data_lo_oe) && (rx_par_oe == rx_data_lo_oe)); // R4

   AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      rx_data_hi_oe |-> rx_data_lo_oe); // R4

   AST_HI_ZERO_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_data_lo_oe && !rx_data_hi_oe) |-> (rx_data[15:8] == 8'h00)); // R7

   AST_NO_CELL_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_avail |-> !rx_data_lo_oe); // R9

   AST_FULL_HAS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_in_ready |-> cell_avail); // R11

endmodule

bind atm_rx_cell_port atm_rx_cell_port_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rd_en_n       (rd_en_n),
   .cell_in_ready (cell_in_ready),
   .cell_avail    (cell_avail),
   .rx_data       (rx_data),
   .rx_soc        (rx_soc),
   .rx_par        (rx_par),
   .rx_data_lo_oe (rx_data_lo_oe),
   .rx_data_hi_oe (rx_data_hi_oe),
   .rx_soc_oe     (rx_soc_oe),
   .rx_par_oe     (rx_par_oe)
);

// File: tb/atm_rx_cell_port_tb_top.sv
module atm_rx_cell_port_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int OCT        = 53;
   localparam int SLOTS      = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        width_strap = 1'b1;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_q;
   logic        cell_in_valid = 1'b0;
   logic [7:0]  cell_in_byte = '0;
   logic        cell_in_ready;
   logic        rd_en_n = 1'b1;
   logic        cell_avail;
   logic [15:0] rx_data;
   logic        rx_soc, rx_par;
   logic        rx_data_lo_oe, rx_data_hi_oe, rx_soc_oe, rx_par_oe;

   atm_rx_cell_port #(.OCTETS(OCT), .SLOTS(SLOTS)) dut_i (
      .clk(clk), .rst_n(rst_n), .width_strap(width_strap),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
      .cell_in_valid(cell_in_valid), .cell_in_byte(cell_in_byte),
      .cell_in_ready(cell_in_ready), .rd_en_n(rd_en_n), .cell_avail(cell_avail),
      .rx_data(rx_data), .rx_soc(rx_soc), .rx_par(rx_par),
      .rx_data_lo_oe(rx_data_lo_oe), .rx_data_hi_oe(rx_data_hi_oe),
      .rx_soc_oe(rx_soc_oe), .rx_par_oe(rx_par_oe)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int  errors = 0;
   int  checks = 0;
   bit  done   = 1'b0;

   byte unsigned ref_q[$];
   int   cells_m;
   int   word_m;
   bit   mode8_m;
   logic [7:0] cfg_m;
   bit   prev_rd;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_word(input bit m8, input int w);
      logic [7:0] lo;
      if (m8) return {8'h00, ref_q[w]};
      lo = (2 * w + 1 < OCT) ? ref_q[2 * w + 1] : 8'h00;
      return {ref_q[2 * w], lo};
   endfunction

   function automatic logic exp_par(input logic [15:0] d);
      return ~(^d);
   endfunction

   task automatic do_reset(input bit strap);
      rst_n = 1'b0; width_strap = strap; cfg_we = 1'b0; cell_in_valid = 1'b0; rd_en_n = 1'b1;
      ref_q.delete();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cells_m = 0; word_m = 0; mode8_m = strap; cfg_m = 8'h00; cfg_m[3] = strap; prev_rd = 1'b0;
      chk("R5", 32'(cfg_q[3]), 32'(strap), "strap latched in cfg bit 3");
      chk("R9", 32'(cell_avail), 0, "cell_avail after reset");
      chk("R3", 32'(rx_data_lo_oe), 0, "oe after reset");
      chk("R11", 32'(cell_in_ready), 1, "ready after reset");
   endtask

   // kind 0: random, 1: all ones, 2: counting
   task automatic push_cell(input int kind);
      for (int i = 0; i < OCT; i++) begin
         byte unsigned b;
         b = (kind == 1) ? 8'hFF : (kind == 2) ? 8'(i + 1) : 8'($urandom_range(255));
         cell_in_valid = 1'b1; cell_in_byte = b;
         ref_q.push_back(b);
         @(negedge clk);
      end
      cell_in_valid = 1'b0;
      cells_m++;
      @(negedge clk);
   endtask

   task automatic read_phase(input int pct, input int cfg_at, input logic [7:0] cfg_val);
      int idle = 0;
      for (int cyc = 0; cyc < 3000 && idle < 4; cyc++) begin
         bit exp_oe;
         bit rd;
         chk("R9", 32'(cell_avail), 32'(cells_m != 0), "cell_avail");
         chk("R11", 32'(cell_in_ready), 32'(cells_m < SLOTS), "ready");
         exp_oe = prev_rd && (cells_m != 0);
         chk("R3", 32'(rx_data_lo_oe), 32'(exp_oe), "data lo oe");
         chk("R4", 32'(rx_soc_oe), 32'(exp_oe), "soc oe");
         chk("R4", 32'(rx_par_oe), 32'(exp_oe), "par oe");
         chk("R4 R5", 32'(rx_data_hi_oe), 32'(exp_oe && !mode8_m), "data hi oe");
         if (exp_oe) begin
            logic [15:0] w;
            bit last;
            w = exp_word(mode8_m, word_m);
            chk(mode8_m ? "R7 R10" : "R6 R10", 32'(rx_data), 32'(w), "data word");
            chk("R2", 32'(rx_soc), 32'(word_m == 0), "start of cell");
            chk("R1", 32'(rx_par), 32'(exp_par(w)), "parity");
            last = (word_m == (mode8_m ? OCT - 1 : (OCT + 1) / 2 - 1));
            if (last) begin
               for (int k = 0; k < OCT; k++) void'(ref_q.pop_front());
               cells_m--; word_m = 0; mode8_m = cfg_m[3];
            end else begin
               word_m++;
            end
         end else begin
            if (cells_m != 0 && word_m != 0)
               chk("R8", 32'(rx_data), 32'(exp_word(mode8_m, word_m)), "held word in pause");
            if (word_m == 0) mode8_m = cfg_m[3];
         end
         rd = ($urandom_range(99) < pct);
         rd_en_n = !rd; prev_rd = rd;
         if (cyc == cfg_at) begin
            cfg_we = 1'b1; cfg_wdata = cfg_val; cfg_m = cfg_val;
         end else begin
            cfg_we = 1'b0;
         end
         if (cells_m == 0) idle++;
         @(negedge clk);
      end
      rd_en_n = 1'b1; cfg_we = 1'b0; prev_rd = 1'b0;
      @(negedge clk);
      if (word_m == 0) mode8_m = cfg_m[3];
   endtask

   initial begin
      void'($urandom(32'h5EED_2811));
      // 8-bit strap
      do_reset(1'b1);
      push_cell(0);
      push_cell(1);
      chk("R11", 32'(cell_in_ready), 0, "ready low when slots full");
      cell_in_valid = 1'b1; cell_in_byte = 8'hA5;
      @(negedge clk);
      cell_in_valid = 1'b0;
      chk("R11", 32'(cell_avail), 1, "avail kept while full");
      read_phase(100, -1, 8'h00);
      push_cell(2);
      push_cell(0);
      read_phase(60, 30, 8'h00);     // switch to 16-bit mid-cell
      push_cell(1);
      push_cell(0);
      read_phase(35, 200, 8'h08);    // back to 8-bit late
      // 16-bit strap
      do_reset(1'b0);
      push_cell(2);
      read_phase(100, -1, 8'h00);
      push_cell(1);
      push_cell(0);
      read_phase(50, 10, 8'h08);     // switch to 8-bit mid-cell
      push_cell(0);
      read_phase(20, 0, 8'h00);      // long pauses, write before start
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired, actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule